// File: doc/BRIEF.md
# Time-Gated Ingress Stream Policer

This block decides, for every frame that reaches an ingress port, whether the frame may pass. Upstream, a classifier matches each frame to a stream index, which stands for a destination address, VLAN ID and priority. It also says whether that stream is subject to timed admission. Each stream can carry a cyclic gate schedule. The schedule is a list of OPEN or CLOSE intervals, each with a length in nanoseconds, and it is anchored to a base time on a synchronized 64-bit nanosecond clock. A gated frame that arrives while its stream's gate is closed is dropped. A frame is also dropped when it has no destination or when it is longer than the configured MTU. Each stream has a frame-count drop counter that any of these reasons advances. No byte count is kept.

Several ingress ports can present frames with the same stream index. All of them are then checked against that one schedule, so sharing a schedule is simply sharing an index. Software builds a schedule with field writes and then commits it. A commit is rejected when the rule has no routing destination (a gate-only rule), when the entry list is malformed, or when its first event would share a 200 ns engine slot with another active stream. Frames enter on a valid/ready handshake, and verdicts leave on another. A verdict that is not taken stalls the frame input: frm_ready follows vrd_ready whenever a verdict is pending.

Top module: `tgp_stream_policer`

## Requirements
- R1: After reset, frm_ready is 1, vrd_valid is 0, cfg_ok and cfg_err are 0, and every drop counter reads 0.
- R2: A gated frame of an active stream is admitted when now_ns lies in an OPEN entry of its schedule and dropped when it lies in a CLOSE entry. Entries follow one another in index order from the base time.
- R3: Before the base time, a gated frame is dropped. After the last used entry, the schedule returns to entry 0, so the position repeats with the sum of the used durations as its period.
- R4: A frame with frm_gated=0 is not checked against any gate. A gated frame of a stream that is not active is dropped.
- R5: A frame with frm_len greater than mtu_bytes is dropped. A frame with frm_len equal to mtu_bytes passes the length check.
- R6: A frame with frm_has_dest=0 is dropped.
- R7: Fields are selected by cfg_field. Code 0 is the base time (all 64 bits). Code 1 is control: bits [2:0] hold the entry count and bit 16 is the route-present flag. Code 2 is the entry at cfg_entry: bits [31:0] hold the duration and bit 63 is 1 for OPEN. A commit is rejected when the route flag is 0, when the count is 0 or above the entry capacity, or when any used duration is below 200 ns.
- R8: A commit is rejected when floor(base/200) equals the stored slot of another active stream.
- R9: cfg_ok or cfg_err pulses for one cycle, in the cycle after cfg_commit. A rejected stream stays inactive, and any field write makes the stream inactive until it is committed again.
- R10: Each dropped frame adds exactly 1 to its stream's counter, whatever the number of reasons. cnt_rdata shows the counter selected by cnt_addr in the same cycle.
- R11: A drop counter holds at its all-ones value.
- R12: cnt_clr zeroes the counter at cnt_addr. A clear takes priority over an increment in the same cycle.
- R13: While vrd_valid=1 and vrd_ready=0, the verdict and its stream stay stable and frm_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| now_ns | input | 64 | Synchronized time in nanoseconds |
| mtu_bytes | input | 14 | Largest admitted frame length |
| cfg_we | input | 1 | Field write strobe |
| cfg_stream | input | 3 | Stream for a write or commit |
| cfg_field | input | 2 | Field code (R7) |
| cfg_entry | input | 2 | Entry index for field code 2 |
| cfg_wdata | input | 64 | Write data |
| cfg_commit | input | 1 | Validate and activate a schedule |
| cfg_ok | output | 1 | Commit accepted pulse |
| cfg_err | output | 1 | Commit rejected pulse |
| frm_valid | input | 1 | Frame descriptor valid |
| frm_ready | output | 1 | Frame descriptor accepted |
| frm_stream | input | 3 | Matched stream index |
| frm_gated | input | 1 | Stream is under timed admission |
| frm_has_dest | input | 1 | Frame has at least one destination |
| frm_len | input | 14 | Frame length in bytes |
| vrd_valid | output | 1 | Verdict valid |
| vrd_ready | input | 1 | Verdict taken |
| vrd_admit | output | 1 | 1 admit, 0 drop |
| vrd_stream | output | 3 | Stream of the verdict |
| cnt_clr | input | 1 | Clear the counter at cnt_addr |
| cnt_addr | input | 3 | Counter select |
| cnt_rdata | output | 16 | Selected drop count |

## Verification
The assertions rely on three properties of the inputs. now_ns never decreases. It never advances by 200 ns or more in a single cycle, so each stream's tracker can follow one gate event per cycle. cfg_we and cfg_commit are never raised in the same cycle. The bench moves time in steps of 100 ns or less, and it holds the time for two cycles before it presents a frame, so the frame never straddles a gate edge. It issues configuration writes and commits in separate cycles. Every frame index it presents is within range.

// File: rtl/tgp_pkg.sv
package tgp_pkg;
  typedef enum logic [1:0] {
    FLD_BASE  = 2'd0,
    FLD_CTRL  = 2'd1,
    FLD_ENTRY = 2'd2
  } cfg_field_e;

  typedef struct packed {
    logic late;
    logic no_route;
    logic oversize;
  } drop_why_t;

  localparam int unsigned CTRL_ROUTE_BIT = 16;
endpackage

// File: rtl/tgp_cfg_bank.sv
module tgp_cfg_bank import tgp_pkg::*; #(
  parameter int unsigned NS      = 8,
  parameter int unsigned NE      = 4,
  parameter int unsigned TW      = 64,
  parameter int unsigned DW      = 32,
  parameter int unsigned SLOT_NS = 200,
  localparam int unsigned SIW    = (NS > 1) ? $clog2(NS) : 1,
  localparam int unsigned EIW    = (NE > 1) ? $clog2(NE) : 1,
  localparam int unsigned NENT_W = $clog2(NE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SIW-1:0]    stream,
  input  logic [1:0]        field,
  input  logic [EIW-1:0]    entry,
  input  logic [TW-1:0]     wdata,
  input  logic              commit,
  output logic              ok_o,
  output logic              err_o,
  output logic [NS-1:0]     active_o,
  output logic [NS-1:0]     restart_o,
  output logic [TW-1:0]     base_o  [NS],
  output logic [NENT_W-1:0] nent_o  [NS],
  output logic [NE-1:0]     open_o  [NS],
  output logic [DW-1:0]     dur_o   [NS][NE]
);
  logic [TW-1:0]     base_q  [NS];
  logic [TW-1:0]     slot_q  [NS];
  logic [NENT_W-1:0] nent_q  [NS];
  logic [NE-1:0]     open_q  [NS];
  logic [DW-1:0]     dur_q   [NS][NE];
  logic [NS-1:0]     route_q;
  logic [NS-1:0]     active_q;
  logic              ok_q, err_q;

  logic              sel_ok, ent_ok, shape_ok, clash, cmt_ok;
  logic [SIW-1:0]    sidx;
  logic [TW-1:0]     cand_slot;

  assign sel_ok = 32'(stream) < NS;
  assign ent_ok = 32'(entry) < NE;
  assign sidx   = sel_ok ? stream : '0;

  // Commit check: shape of the entry list, routing, and first-event slot
  always_comb begin
    cand_slot = base_q[sidx] / TW'(SLOT_NS);
    shape_ok  = route_q[sidx] && (nent_q[sidx] != '0) && (32'(nent_q[sidx]) <= NE);
    for (int e = 0; e < NE; e++) begin
      if ((32'(e) < 32'(nent_q[sidx])) && (dur_q[sidx][e] < DW'(SLOT_NS)))
        shape_ok = 1'b0;
    end
    clash = 1'b0;
    for (int j = 0; j < NS; j++) begin
      if (active_q[j] && (SIW'(j) != sidx) && (slot_q[j] == cand_slot))
        clash = 1'b1;
    end
    cmt_ok = shape_ok && !clash;
  end

  always_comb begin
    restart_o = '0;
    if (commit && !we && sel_ok && cmt_ok) restart_o[sidx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      route_q  <= '0;
      ok_q     <= 1'b0;
      err_q    <= 1'b0;
      for (int s = 0; s < NS; s++) begin
        base_q[s] <= '0;
        slot_q[s] <= '0;
        nent_q[s] <= '0;
        open_q[s] <= '0;
        for (int e = 0; e < NE; e++) dur_q[s][e] <= '0;
      end
    end else begin
      ok_q  <= 1'b0;
      err_q <= 1'b0;
      if (we && sel_ok) begin
        active_q[sidx] <= 1'b0;
        case (cfg_field_e'(field))
          FLD_BASE: base_q[sidx] <= wdata;
          FLD_CTRL: begin
            nent_q[sidx]  <= wdata[NENT_W-1:0];
            route_q[sidx] <= wdata[CTRL_ROUTE_BIT];
          end
          FLD_ENTRY: if (ent_ok) begin
            dur_q[sidx][entry]  <= wdata[DW-1:0];
            open_q[sidx][entry] <= wdata[TW-1];
          end
          default: ;
        endcase
      end else if (commit && sel_ok) begin
        active_q[sidx] <= cmt_ok;
        slot_q[sidx]   <= cand_slot;
        ok_q           <= cmt_ok;
        err_q          <= !cmt_ok;
      end
    end
  end

  assign ok_o     = ok_q;
  assign err_o    = err_q;
  assign active_o = active_q;
  assign base_o   = base_q;
  assign nent_o   = nent_q;
  assign open_o   = open_q;
  assign dur_o    = dur_q;
endmodule

// File: rtl/tgp_gate_tracker.sv
module tgp_gate_tracker #(
  parameter int unsigned NE      = 4,
  parameter int unsigned TW      = 64,
  parameter int unsigned DW      = 32,
  localparam int unsigned EIW    = (NE > 1) ? $clog2(NE) : 1,
  localparam int unsigned NENT_W = $clog2(NE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     now,
  input  logic              restart,
  input  logic              active,
  input  logic [TW-1:0]     base,
  input  logic [NENT_W-1:0] nent,
  input  logic [NE-1:0]     open_bits,
  input  logic [DW-1:0]     dur [NE],
  output logic              gate_open
);
  logic           started_q;
  logic [EIW-1:0] idx_q, wrap_idx, nxt_idx;
  logic [TW-1:0]  next_ev_q;

  always_comb begin
    wrap_idx = ((32'(idx_q) + 1) >= 32'(nent)) ? '0 : idx_q + 1'b1;
    nxt_idx  = started_q ? wrap_idx : '0;
  end

  // One gate event per cycle: next_ev_q is the time of the next edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      idx_q     <= '0;
      next_ev_q <= '0;
    end else if (restart) begin
      started_q <= 1'b0;
      idx_q     <= '0;
      next_ev_q <= base;
    end else if (active && (now >= next_ev_q)) begin
      started_q <= 1'b1;
      idx_q     <= nxt_idx;
      next_ev_q <= next_ev_q + TW'(dur[nxt_idx]);
    end
  end

  assign gate_open = active && started_q && open_bits[idx_q];
endmodule

// File: rtl/tgp_drop_counters.sv
module tgp_drop_counters #(
  parameter int unsigned NS    = 8,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned SIW  = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic [SIW-1:0]   inc_idx,
  input  logic             clr,
  input  logic [SIW-1:0]   clr_idx,
  input  logic [SIW-1:0]   rd_idx,
  output logic [CNT_W-1:0] rd_data
);
  logic [CNT_W-1:0] cnt_q [NS];

  for (genvar g = 0; g < NS; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt_q[g] <= '0;
      else if (clr && (32'(clr_idx) == g))
        cnt_q[g] <= '0;
      else if (inc && (32'(inc_idx) == g) && (cnt_q[g] != '1))
        cnt_q[g] <= cnt_q[g] + 1'b1;
    end
  end

  assign rd_data = (32'(rd_idx) < NS) ? cnt_q[rd_idx] : '0;
endmodule

// File: rtl/tgp_stream_policer.sv
module tgp_stream_policer import tgp_pkg::*; #(
  parameter int unsigned NS      = 8,
  parameter int unsigned NE      = 4,
  parameter int unsigned TW      = 64,
  parameter int unsigned DW      = 32,
  parameter int unsigned LEN_W   = 14,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned SLOT_NS = 200,
  localparam int unsigned SIW    = (NS > 1) ? $clog2(NS) : 1,
  localparam int unsigned EIW    = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    now_ns,
  input  logic [LEN_W-1:0] mtu_bytes,
  input  logic             cfg_we,
  input  logic [SIW-1:0]   cfg_stream,
  input  logic [1:0]       cfg_field,
  input  logic [EIW-1:0]   cfg_entry,
  input  logic [TW-1:0]    cfg_wdata,
  input  logic             cfg_commit,
  output logic             cfg_ok,
  output logic             cfg_err,
  input  logic             frm_valid,
  output logic             frm_ready,
  input  logic [SIW-1:0]   frm_stream,
  input  logic             frm_gated,
  input  logic             frm_has_dest,
  input  logic [LEN_W-1:0] frm_len,
  output logic             vrd_valid,
  input  logic             vrd_ready,
  output logic             vrd_admit,
  output logic [SIW-1:0]   vrd_stream,
  input  logic             cnt_clr,
  input  logic [SIW-1:0]   cnt_addr,
  output logic [CNT_W-1:0] cnt_rdata
);
  localparam int unsigned NENT_W = $clog2(NE + 1);

  logic [NS-1:0]     sch_active, sch_restart, gate_open;
  logic [TW-1:0]     sch_base [NS];
  logic [NENT_W-1:0] sch_nent [NS];
  logic [NE-1:0]     sch_open [NS];
  logic [DW-1:0]     sch_dur  [NS][NE];

  tgp_cfg_bank #(.NS(NS), .NE(NE), .TW(TW), .DW(DW), .SLOT_NS(SLOT_NS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .stream(cfg_stream), .field(cfg_field),
    .entry(cfg_entry), .wdata(cfg_wdata), .commit(cfg_commit),
    .ok_o(cfg_ok), .err_o(cfg_err), .active_o(sch_active), .restart_o(sch_restart),
    .base_o(sch_base), .nent_o(sch_nent), .open_o(sch_open), .dur_o(sch_dur)
  );

  for (genvar g = 0; g < NS; g++) begin : g_trk
    tgp_gate_tracker #(.NE(NE), .TW(TW), .DW(DW)) u_trk (
      .clk(clk), .rst_n(rst_n), .now(now_ns), .restart(sch_restart[g]),
      .active(sch_active[g]), .base(sch_base[g]), .nent(sch_nent[g]),
      .open_bits(sch_open[g]), .dur(sch_dur[g]), .gate_open(gate_open[g])
    );
  end

  // Verdict stage
  drop_why_t why;
  logic      fire, admit_c;

  assign frm_ready    = !vrd_valid || vrd_ready;
  assign fire         = frm_valid && frm_ready;
  assign why.late     = frm_gated && !gate_open[frm_stream];
  assign why.no_route = !frm_has_dest;
  assign why.oversize = frm_len > mtu_bytes;
  assign admit_c      = (why == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vrd_valid  <= 1'b0;
      vrd_admit  <= 1'b0;
      vrd_stream <= '0;
    end else if (fire) begin
      vrd_valid  <= 1'b1;
      vrd_admit  <= admit_c;
      vrd_stream <= frm_stream;
    end else if (vrd_ready) begin
      vrd_valid  <= 1'b0;
    end
  end

  tgp_drop_counters #(.NS(NS), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(fire && !admit_c), .inc_idx(frm_stream),
    .clr(cnt_clr), .clr_idx(cnt_addr), .rd_idx(cnt_addr), .rd_data(cnt_rdata)
  );
endmodule

// File: rtl/tgp_stream_policer_chk.sv
module tgp_stream_policer_chk #(
  parameter int unsigned NS    = 8,
  parameter int unsigned LEN_W = 14,
  localparam int unsigned SIW  = (NS > 1) ? $clog2(NS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_valid,
  input logic             frm_ready,
  input logic [SIW-1:0]   frm_stream,
  input logic             frm_gated,
  input logic             frm_has_dest,
  input logic [LEN_W-1:0] frm_len,
  input logic [LEN_W-1:0] mtu_bytes,
  input logic             vrd_valid,
  input logic             vrd_ready,
  input logic             vrd_admit,
  input logic [SIW-1:0]   vrd_stream,
  input logic             cfg_ok,
  input logic             cfg_err,
  input logic [NS-1:0]    gate_open
);
  AST_CLOSED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && frm_ready && frm_gated && !gate_open[frm_stream] |=> vrd_valid && !vrd_admit); // R2
  AST_OPEN_ADMITS: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && frm_ready && frm_gated && gate_open[frm_stream] && frm_has_dest && (frm_len <= mtu_bytes)
    |=> vrd_valid && vrd_admit); // R2
  AST_OVERSIZE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && frm_ready && (frm_len > mtu_bytes) |=> vrd_valid && !vrd_admit); // R5
  AST_NO_DEST_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && frm_ready && !frm_has_dest |=> vrd_valid && !vrd_admit); // R6
  AST_CFG_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_ok && cfg_err)); // R9
  AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    vrd_valid && !vrd_ready |=> vrd_valid && $stable(vrd_admit) && $stable(vrd_stream)); // R13
endmodule

bind tgp_stream_policer tgp_stream_policer_chk #(.NS(NS), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
  .frm_stream(frm_stream), .frm_gated(frm_gated), .frm_has_dest(frm_has_dest),
  .frm_len(frm_len), .mtu_bytes(mtu_bytes), .vrd_valid(vrd_valid), .vrd_ready(vrd_ready),
  .vrd_admit(vrd_admit), .vrd_stream(vrd_stream), .cfg_ok(cfg_ok), .cfg_err(cfg_err),
  .gate_open(gate_open)
);

// File: tb/tgp_stream_policer_bench.sv
`timescale 1ns/1ps
module tgp_stream_policer_bench;
  localparam int unsigned CW = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [63:0] now_ns = '0, cfg_wdata = '0;
  logic [13:0] mtu_bytes = 14'd1500, frm_len = '0;
  logic        cfg_we = 0, cfg_commit = 0, cfg_ok, cfg_err;
  logic [2:0]  cfg_stream = '0, frm_stream = '0, vrd_stream, cnt_addr = '0;
  logic [1:0]  cfg_field = '0, cfg_entry = '0;
  logic        frm_valid = 0, frm_ready, frm_gated = 0, frm_has_dest = 0;
  logic        vrd_valid, vrd_ready = 1, vrd_admit, cnt_clr = 0;
  logic [CW-1:0] cnt_rdata;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  tgp_stream_policer #(.CNT_W(CW)) u_tgp_stream_policer (.*);

  typedef struct packed {
    logic [63:0] t; logic [2:0] s; logic g; logic d; logic [13:0] len; logic adm;
  } vec_t;

  // Stream 0: base 10000, OPEN 600 / CLOSE 400. Stream 1: base 10200, CLOSE 300 / OPEN 300 / OPEN 400.
  localparam vec_t VEC [15] = '{
    '{64'd9000,  3'd0, 1'b1, 1'b1, 14'd100,  1'b0},  // R3 before base
    '{64'd9000,  3'd0, 1'b0, 1'b1, 14'd100,  1'b1},  // R4 ungated
    '{64'd10300, 3'd0, 1'b1, 1'b1, 14'd100,  1'b1},  // R2 open
    '{64'd10300, 3'd1, 1'b1, 1'b1, 14'd100,  1'b0},  // R2 closed
    '{64'd10700, 3'd0, 1'b1, 1'b1, 14'd100,  1'b0},  // R2 closed
    '{64'd10700, 3'd1, 1'b1, 1'b1, 14'd100,  1'b1},  // R2 open
    '{64'd10700, 3'd0, 1'b1, 1'b1, 14'd1600, 1'b0},  // R5 oversize
    '{64'd10700, 3'd1, 1'b1, 1'b1, 14'd1500, 1'b1},  // R5 equal mtu
    '{64'd10700, 3'd1, 1'b1, 1'b0, 14'd100,  1'b0},  // R6 no dest
    '{64'd11100, 3'd1, 1'b1, 1'b1, 14'd100,  1'b1},  // R2 third entry
    '{64'd11300, 3'd1, 1'b1, 1'b1, 14'd100,  1'b0},  // R3 wrap
    '{64'd12400, 3'd0, 1'b1, 1'b1, 14'd100,  1'b1},  // R3 second cycle
    '{64'd12800, 3'd0, 1'b1, 1'b1, 14'd100,  1'b0},  // R3 second cycle
    '{64'd12800, 3'd2, 1'b1, 1'b1, 14'd100,  1'b0},  // R4 inactive
    '{64'd12800, 3'd2, 1'b0, 1'b1, 14'd100,  1'b1}   // R4 ungated
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step_to(input logic [63:0] t);
    while (now_ns < t) begin
      @(negedge clk);
      now_ns = (t - now_ns > 64'd100) ? now_ns + 64'd100 : t;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] s, input logic [1:0] f, input logic [1:0] e, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_stream = s; cfg_field = f; cfg_entry = e; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic commit(input logic [2:0] s, output logic ok, output logic err);
    @(negedge clk);
    cfg_commit = 1; cfg_stream = s;
    @(negedge clk);
    cfg_commit = 0;
    ok = cfg_ok; err = cfg_err;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [2:0] s, input logic g, input logic d, input logic [13:0] len,
                      output logic vv, output logic adm);
    @(negedge clk);
    frm_valid = 1; frm_stream = s; frm_gated = g; frm_has_dest = d; frm_len = len;
    @(negedge clk);
    frm_valid = 0;
    vv = vrd_valid; adm = vrd_admit;
  endtask

  function automatic logic [63:0] ent(input logic op, input logic [31:0] dur);
    return {op, 31'd0, dur};
  endfunction

  function automatic logic [63:0] ctl(input logic route, input logic [2:0] n);
    return (64'(route) << 16) | 64'(n);
  endfunction

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run completion)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ok, err, vv, adm;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 frm_ready", frm_ready, 1);
    chk("R1 vrd_valid", vrd_valid, 0);
    chk("R1 cfg flags", {cfg_ok, cfg_err}, 0);
    chk("R1 counter", cnt_rdata, 0);
    rst_n = 1;
    @(negedge clk);

    wr(0, 0, 0, 64'd10000); wr(0, 1, 0, ctl(1, 2));
    wr(0, 2, 0, ent(1, 600)); wr(0, 2, 1, ent(0, 400));
    commit(0, ok, err);
    chk("R9 commit s0 ok", {ok, err}, 2'b10);
    wr(1, 0, 0, 64'd10200); wr(1, 1, 0, ctl(1, 3));
    wr(1, 2, 0, ent(0, 300)); wr(1, 2, 1, ent(1, 300)); wr(1, 2, 2, ent(1, 400));
    commit(1, ok, err);
    chk("R8 adjacent slot accepted", {ok, err}, 2'b10);

    for (int i = 0; i < 15; i++) begin
      step_to(VEC[i].t);
      send(VEC[i].s, VEC[i].g, VEC[i].d, VEC[i].len, vv, adm);
      chk($sformatf("R2 vector %0d valid", i), vv, 1);
      chk($sformatf("R2 vector %0d admit", i), adm, VEC[i].adm);
    end

    // R10 per-stream counts
    @(negedge clk); cnt_addr = 0; #1 chk("R10 count s0", cnt_rdata, 4);
    cnt_addr = 1; #1 chk("R10 count s1", cnt_rdata, 3);
    cnt_addr = 2; #1 chk("R10 count s2", cnt_rdata, 1);

    // R7 / R8 rejects on stream 3
    wr(3, 0, 0, 64'd20000); wr(3, 1, 0, ctl(0, 2));
    wr(3, 2, 0, ent(1, 400)); wr(3, 2, 1, ent(0, 400));
    commit(3, ok, err); chk("R7 gate-only rejected", {ok, err}, 2'b01);
    wr(3, 1, 0, ctl(1, 0));
    commit(3, ok, err); chk("R7 zero entries rejected", {ok, err}, 2'b01);
    wr(3, 1, 0, ctl(1, 2)); wr(3, 2, 1, ent(0, 150));
    commit(3, ok, err); chk("R7 short duration rejected", {ok, err}, 2'b01);
    wr(3, 2, 1, ent(0, 400)); wr(3, 0, 0, 64'd10050);
    commit(3, ok, err); chk("R8 same slot rejected", {ok, err}, 2'b01);
    send(3, 1, 1, 100, vv, adm); chk("R9 rejected stays inactive", adm, 0);

    wr(3, 0, 0, 64'd12000); wr(3, 1, 0, ctl(1, 1)); wr(3, 2, 0, ent(1, 1000));
    commit(3, ok, err); chk("R9 commit s3 ok", {ok, err}, 2'b10);
    send(3, 1, 1, 100, vv, adm); chk("R2 s3 open", adm, 1);
    wr(3, 0, 0, 64'd12000);
    send(3, 1, 1, 100, vv, adm); chk("R9 write deactivates", adm, 0);

    // R13 back-pressure
    @(negedge clk); vrd_ready = 0;
    send(0, 0, 1, 100, vv, adm);
    repeat (3) @(negedge clk);
    chk("R13 verdict held", {vrd_valid, vrd_admit, vrd_stream}, {1'b1, 1'b1, 3'd0});
    chk("R13 frm_ready low", frm_ready, 0);
    vrd_ready = 1;
    @(negedge clk);
    chk("R13 verdict taken", vrd_valid, 0);

    // R11 saturation on stream 2
    for (int k = 0; k < 20; k++) send(2, 0, 0, 100, vv, adm);
    cnt_addr = 2; #1 chk("R11 saturated", cnt_rdata, 15);

    // R12 clear wins over increment
    @(negedge clk);
    cnt_clr = 1; cnt_addr = 2;
    frm_valid = 1; frm_stream = 2; frm_gated = 0; frm_has_dest = 0;
    @(negedge clk);
    cnt_clr = 0; frm_valid = 0;
    #1 chk("R12 clear priority", cnt_rdata, 0);
    send(2, 0, 0, 100, vv, adm);
    #1 chk("R10 count after clear", cnt_rdata, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule